// File: doc/BRIEF.md
# Scan-Testable Memory Wrapper

This block places a small synchronous-write memory inside mux-scan test logic, so that the memory does not hide nearby logic during structural test. Every flop in the wrapper has a two-way selector at its D input. When the shift enable is high, the selector takes the previous element of the chain. When it is low, the selector takes the functional next value. All flops form one serial chain from `si` to `so`, clocked by `clk`.

Observe flops sit on the memory's address and write-data inputs and record those inputs on each capture edge. Control flops stand in for the memory's read word while `test_mode` is 1, so downstream logic can be set to any value through the chain. The downstream logic here is a registered read output, and it is part of the chain too. With `test_mode` at 0 the control flops are bypassed and the true stored word reaches the output.

A test loads a pattern with `se` high, lowers `se` for one capture edge, and then raises `se` again. The captured state then shifts out while the next pattern shifts in. The chain is 3*DW+AW flops long. The memory never writes while `se` is high, so shifting leaves its contents intact.

Top module: `scan_mem_wrap`

## Requirements
- R1: When `rst` is high at a clock edge, every chain flop clears to 0, so `so` and `rdata` read 0 after that edge.
- R2: On each edge with `se`=1, chain position 0 takes `si` and position k takes the old position k-1. `so` always shows the last position, 3*DW+AW-1. A pattern loaded with 3*DW+AW shifts comes back unchanged on the next 3*DW+AW shifts.
- R3: Chain positions, counted from `si`, are fixed as follows. Positions 0..DW-1 hold the read output register (bit i at position i). The next AW positions hold address observe bits. The next DW positions hold write-data observe bits. The last DW positions hold the control bits.
- R4: On an edge with `se`=0, the address observe flops take the value of `addr`.
- R5: On an edge with `se`=0, the write-data observe flops take the value of `wdata`.
- R6: On an edge with `se`=0, the control flops keep their value.
- R7: With `test_mode`=1 and `se`=0, the read output register takes the control flop value, so `rdata` equals the shifted-in control bits after the capture edge.
- R8: With `test_mode`=0 and `se`=0, `rdata` after an edge equals the word stored at the `addr` presented before that edge.
- R9: A word is written at `addr` only on an edge with `we`=1 and `se`=0. With `se`=1, memory contents do not change whatever `we`, `addr` and `wdata` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for memory and chain |
| rst | input | 1 | Synchronous reset, active high |
| test_mode | input | 1 | 1 selects control flops as the read word |
| se | input | 1 | Shift enable, active high |
| si | input | 1 | Serial chain input |
| so | output | 1 | Serial chain output |
| we | input | 1 | Memory write enable |
| addr | input | AW | Memory address |
| wdata | input | DW | Memory write word |
| rdata | output | DW | Registered read word |

## Verification
Two functions can fall on the same edge. A capture cycle can also carry a memory write, so the observe flops record `addr` and `wdata` on the same edge the memory stores them. The bench issues `we`=1 in every other capture cycle. It judges the unloaded observe fields against the driven values, and later reads the memory back in functional mode against a model array. In the same way, each unload overlaps the next load. The memory is offered a conflicting write throughout each shift, and the stored word must survive.

// File: rtl/scan_wrap_pkg.sv
package scan_wrap_pkg;
  // Number of chain elements: output register, address, data, control.
  function automatic int chain_len(input int aw, input int dw);
    return 3 * dw + aw;
  endfunction
endpackage

// File: rtl/scan_seg.sv
module scan_seg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         se,
  input  logic         sin,
  input  logic [W-1:0] func_d,
  output logic [W-1:0] q,
  output logic         sout
);
  logic [W-1:0] prev;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_head
        assign prev[i] = sin;
      end else begin : g_body
        assign prev[i] = q[i-1];
      end
      always_ff @(posedge clk) begin
        if (rst) q[i] <= 1'b0;
        else     q[i] <= se ? prev[i] : func_d[i];
      end
    end
  endgenerate

  assign sout = q[W-1];

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    se |=> q[0] == $past(sin));
endmodule

// File: rtl/mem_array.sv
module mem_array #(
  parameter int AW = 3,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          se,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && !se) mem[addr] <= wdata;
  end

  assign rd = mem[addr];

  // R9
  no_shift_write_chk: assert property (@(posedge clk) disable iff (rst)
    se |=> mem[$past(addr)] == $past(mem[addr]));
endmodule

// File: rtl/rd_select.sv
module rd_select #(
  parameter int DW = 4
) (
  input  logic          test_mode,
  input  logic [DW-1:0] ram_rd,
  input  logic [DW-1:0] ctl,
  output logic [DW-1:0] dsel
);
  always_comb begin
    dsel = test_mode ? ctl : ram_rd;
  end
endmodule

// File: rtl/scan_mem_wrap.sv
module scan_mem_wrap
  import scan_wrap_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          test_mode,
  input  logic          se,
  input  logic          si,
  output logic          so,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int LEN = chain_len(AW, DW);

  logic [DW-1:0] out_q, dobs_q, ctl_q, ram_rd, dsel;
  logic [AW-1:0] aobs_q;
  logic s_out, s_adr, s_dat, s_ctl;

  mem_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst(rst), .se(se), .we(we), .addr(addr),
    .wdata(wdata), .rd(ram_rd)
  );

  rd_select #(.DW(DW)) u_sel (
    .test_mode(test_mode), .ram_rd(ram_rd), .ctl(ctl_q), .dsel(dsel)
  );

  // Chain: output register -> address observe -> data observe -> control.
  scan_seg #(.W(DW)) u_seg_out (
    .clk(clk), .rst(rst), .se(se), .sin(si),
    .func_d(dsel), .q(out_q), .sout(s_out)
  );
  scan_seg #(.W(AW)) u_seg_adr (
    .clk(clk), .rst(rst), .se(se), .sin(s_out),
    .func_d(addr), .q(aobs_q), .sout(s_adr)
  );
  scan_seg #(.W(DW)) u_seg_dat (
    .clk(clk), .rst(rst), .se(se), .sin(s_adr),
    .func_d(wdata), .q(dobs_q), .sout(s_dat)
  );
  scan_seg #(.W(DW)) u_seg_ctl (
    .clk(clk), .rst(rst), .se(se), .sin(s_dat),
    .func_d(ctl_q), .q(ctl_q), .sout(s_ctl)
  );

  assign so    = s_ctl;
  assign rdata = out_q;

  initial begin
    if (LEN < 2) $error("chain too short");
  end

  // R2
  chain_tail_chk: assert property (@(posedge clk) disable iff (rst)
    se |=> so == $past(ctl_q[DW-2]));
  // R4
  addr_obs_chk: assert property (@(posedge clk) disable iff (rst)
    !se |=> aobs_q == $past(addr));
  // R5
  data_obs_chk: assert property (@(posedge clk) disable iff (rst)
    !se |=> dobs_q == $past(wdata));
  // R6
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !se |=> $stable(ctl_q));
  // R7
  test_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (test_mode && !se) |=> rdata == $past(ctl_q));
  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && !se) |=> rdata == $past(ram_rd));
endmodule

// File: tb/tb_scan_mem_wrap.sv
module tb_scan_mem_wrap;
  localparam int AW = 3;
  localparam int DW = 4;
  localparam int LEN = 3 * DW + AW;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] SHADDR = AW'(DEPTH - 1);

  logic clk = 1'b0;
  logic rst, test_mode, se, si, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic so;
  logic [DW-1:0] rdata;

  logic [DW-1:0] ref_mem [DEPTH];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scan_mem_wrap #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .test_mode(test_mode), .se(se), .si(si), .so(so),
    .we(we), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Load p while unloading the previous chain contents into u.
  task automatic shift_pat(input logic [LEN-1:0] p, output logic [LEN-1:0] u);
    for (int j = 0; j < LEN; j++) begin
      se = 1'b1;
      si = p[LEN-1-j];
      we = 1'b1;
      addr = SHADDR;
      wdata = ~ref_mem[SHADDR];
      u[LEN-1-j] = so;
      @(posedge clk);
      @(negedge clk);
    end
    se = 1'b0;
    we = 1'b0;
  endtask

  task automatic check_fields(input logic [LEN-1:0] u, input logic [LEN-1:0] e);
    check("R3 R7 out field", 32'(u[DW-1:0]), 32'(e[DW-1:0]));
    check("R4 addr field", 32'(u[DW+AW-1:DW]), 32'(e[DW+AW-1:DW]));
    check("R5 data field", 32'(u[2*DW+AW-1:DW+AW]), 32'(e[2*DW+AW-1:DW+AW]));
    check("R6 ctl field", 32'(u[LEN-1:2*DW+AW]), 32'(e[LEN-1:2*DW+AW]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [LEN-1:0] u, p, e;
    rst = 1'b1; test_mode = 1'b0; se = 1'b0; si = 1'b0; we = 1'b0;
    addr = '0; wdata = '0;
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state at ports and through the chain
    check("R1 rdata", 32'(rdata), 0);
    check("R1 so", 32'(so), 0);

    // R9 R8 functional writes then reads, all addresses
    for (int a = 0; a < DEPTH; a++) begin
      we = 1'b1; addr = AW'(a); wdata = DW'((a * 5 + 3) % 16);
      ref_mem[a] = wdata;
      @(posedge clk); @(negedge clk);
    end
    we = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      addr = AW'(a);
      @(posedge clk); @(negedge clk);
      check("R8 bypass read", 32'(rdata), 32'(ref_mem[a]));
    end

    // Chain contents after functional cycles: out=last read, addr, data, ctl=0
    test_mode = 1'b1;
    e = {DW'(0), wdata, addr, ref_mem[DEPTH-1]};
    p = LEN'(15'h2A5C);
    shift_pat(p, u);
    check_fields(u, e);
    // R2 pattern returns unchanged on the next unload
    e = p;
    p = LEN'(15'h51B3);
    shift_pat(p, u);
    check("R2 shift loop", 32'(u), 32'(e));
    e = p;
    p = '0;
    shift_pat(p, u);
    check("R2 shift loop 2", 32'(u), 32'(e));
    check("R2 so after zero load", 32'(so), 0);

    // Load, capture, unload for a sweep of patterns
    p = LEN'(15'h1357);
    shift_pat(p, u);
    for (int k = 0; k < 16; k++) begin
      logic [AW-1:0] ak;
      logic [DW-1:0] dk;
      logic [LEN-1:0] nxt;
      ak = AW'((k * 3 + 1) % DEPTH);
      dk = DW'((k * 7 + 2) % 16);
      test_mode = 1'b1; se = 1'b0; addr = ak; wdata = dk; we = k[0];
      if (k[0] && ak != SHADDR) ref_mem[ak] = dk;
      else if (k[0]) ref_mem[ak] = dk;
      @(posedge clk); @(negedge clk);
      we = 1'b0;
      // R7 control word reaches rdata on the capture edge
      check("R7 rdata from control", 32'(rdata), 32'(p[LEN-1:2*DW+AW]));
      e = {p[LEN-1:2*DW+AW], dk, ak, p[LEN-1:2*DW+AW]};
      nxt = LEN'((k * 16'h2F1B + 16'h0A5C) ^ (k << 7));
      shift_pat(nxt, u);
      check_fields(u, e);
      p = nxt;
    end

    // R9 memory reads back with capture writes kept and shift writes absent
    test_mode = 1'b0; se = 1'b0; we = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      addr = AW'(a);
      @(posedge clk); @(negedge clk);
      check("R9 stored word", 32'(rdata), 32'(ref_mem[a]));
    end

    // R1 reset in mid-operation clears the whole chain
    test_mode = 1'b1;
    p = '1;
    shift_pat(p, u);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 rdata after reset", 32'(rdata), 0);
    shift_pat('0, u);
    check("R1 chain after reset", 32'(u), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule